// File: doc/BRIEF.md
# Segment Selector Descriptor Loader

This block carries out one segment-register load. A load request names one of six segment registers and supplies a 16-bit selector. The block splits the selector into a descriptor index, a table choice and a requested privilege level. It then picks the global or the local descriptor table. Before any memory traffic, it checks the 8-byte slot against that table's limit and forms the slot's byte address. The descriptor is fetched as one 64-bit word through a request/valid read port.

The fetched word is checked for its present bit. Its scattered base and limit fragments are joined, and the result is written with the type, privilege and flag bits into a hidden per-register cache. The selector is written into the same cache entry in the same cycle.

Null selectors are handled per register. The code and stack registers refuse a null selector with a fault. Any other register accepts it without a memory read, and its entry is marked so that a later memory reference through it traps. Both table base/limit pairs are written through a plain configuration port. Software reads a cache entry back through a registered read port.

Top module: `seg_desc_loader`

## Requirements
- R1: The selector is decoded as index = sel[15:3], table bit = sel[2] (0 picks the global table, 1 the local table) and privilege = sel[1:0]. A read is issued at mem_addr = chosen table base + index*8, and mem_req stays high with a stable address until mem_valid is seen.
- R2: If index*8+7 is greater than the chosen table's byte limit, the load ends with ld_fault and ld_cause = 3. No memory read is issued and the cache entry is left unchanged. A slot whose last byte equals the limit is accepted.
- R3: A null selector (index 0, table bit 0, any privilege) loaded into register 1 (code) or register 2 (stack) ends with ld_fault and ld_cause = 1. No memory read is issued and the entry is unchanged.
- R4: A null selector loaded into any other register ends with ld_done and no memory read. The entry then holds the given selector, all other fields zero, and rd_null = 1. An acc_req naming that register gives acc_trap = 1 in the next cycle.
- R5: A fetched descriptor with bit 47 (present) clear ends the load with ld_fault and ld_cause = 2, and the entry is left unchanged.
- R6: The descriptor word is unpacked as follows:
  - limit[15:0] comes from bits 15:0 and limit[19:16] from bits 51:48.
  - base[23:0] comes from bits 39:16 and base[31:24] from bits 63:56.
  - type comes from bits 43:40, S from bit 44, privilege from bits 46:45, the available bit from bit 52, the default-size bit from bit 54 and granularity from bit 55.
- R7: A successful descriptor load writes the selector and all unpacked fields into the entry at once and clears rd_null, so acc_req on that register no longer traps.
- R8: Every accepted load ends with exactly one one-cycle pulse, either ld_done with ld_cause = 0 or ld_fault with a non-zero ld_cause, never both.
- R9: ld_busy is high from the cycle after a load is accepted until the cycle its outcome pulses, when it is low. A ld_req seen while busy is ignored.
- R10: After reset the block is idle with no pulse and no read pending. Every entry reads back as selector 0 with all fields zero and rd_null = 1, and acc_req on it traps.
- R11: A configuration write with cfg_tbl = 0 sets the global table's base and limit, and one with cfg_tbl = 1 sets the local table's. Later loads use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table register write strobe |
| cfg_tbl | input | 1 | Table written: 0 global, 1 local |
| cfg_base | input | ADDR_W | Table linear base address |
| cfg_lim | input | TLIM_W | Table byte limit |
| ld_req | input | 1 | Load request (taken when idle) |
| ld_seg | input | SEGW | Target segment register |
| ld_sel | input | 16 | Selector to load |
| ld_busy | output | 1 | Load in flight |
| ld_done | output | 1 | Load completed pulse |
| ld_fault | output | 1 | Load refused pulse |
| ld_cause | output | 2 | 0 none, 1 null into code/stack, 2 not present, 3 over table limit |
| mem_req | output | 1 | Descriptor read request, held until mem_valid |
| mem_addr | output | ADDR_W | Descriptor byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor word |
| rd_seg | input | SEGW | Register read back |
| rd_sel | output | 16 | Stored selector |
| rd_base | output | 32 | Stored segment base |
| rd_limit | output | 20 | Stored segment limit |
| rd_type | output | 4 | Stored type field |
| rd_s | output | 1 | Stored S bit |
| rd_dpl | output | 2 | Stored descriptor privilege |
| rd_avl | output | 1 | Stored available bit |
| rd_db | output | 1 | Stored default-size bit |
| rd_gran | output | 1 | Stored granularity bit |
| rd_null | output | 1 | Entry holds a null selector |
| acc_req | input | 1 | Memory reference through a register |
| acc_seg | input | SEGW | Register used by the reference |
| acc_trap | output | 1 | Reference traps (next cycle) |

## Verification
The hardest situations to reach from the ports are two. The first is a second request arriving while a descriptor read is outstanding. The second is a fault that must leave a previously loaded entry untouched. The bench's memory model answers after a random delay of one to four cycles, which holds ld_busy high long enough to pulse a competing ld_req during the read. A switchable present bit in the modelled descriptors lets a not-present fault land on a register that already holds a valid load. A readback then shows the old contents. Table limits are placed so that both the last fitting slot and the first slot beyond the limit are loaded, in both tables and again after a limit rewrite.

// File: rtl/seg_ldr_pkg.sv
package seg_ldr_pkg;

  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;

  typedef enum logic [1:0] {
    CAUSE_NONE        = 2'd0,
    CAUSE_NULL_CS_SS  = 2'd1,
    CAUSE_NOT_PRESENT = 2'd2,
    CAUSE_OVER_LIMIT  = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2
  } ldr_state_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [31:0]      base;
    logic [19:0]      limit;
    logic [3:0]       typ;
    logic             s;
    logic [1:0]       dpl;
    logic             avl;
    logic             db;
    logic             gran;
    logic             unusable;
  } seg_cache_t;

  localparam seg_cache_t CACHE_RST = '{unusable: 1'b1, default: '0};

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
  parameter int ADDR_W = 32,
  parameter int TLIM_W = 16
)(
  input  logic [13:0]       sel_hi,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [TLIM_W-1:0] gdt_lim,
  input  logic [ADDR_W-1:0] ldt_base,
  input  logic [TLIM_W-1:0] ldt_lim,
  output logic              is_null,
  output logic              over_limit,
  output logic [ADDR_W-1:0] desc_addr
);
  localparam int IDX_W = 13;
  localparam int OFF_W = IDX_W + 3;
  localparam int CMP_W = TLIM_W + OFF_W + 1;

  logic [IDX_W-1:0]  idx;
  logic              ti;
  logic [OFF_W-1:0]  off;
  logic [CMP_W-1:0]  last_byte;
  logic [CMP_W-1:0]  lim_ext;
  logic [ADDR_W-1:0] tbl_base;

  assign idx       = sel_hi[13:1];
  assign ti        = sel_hi[0];
  assign off       = {idx, 3'b000};
  assign last_byte = CMP_W'(off) + CMP_W'(7);
  assign lim_ext   = ti ? CMP_W'(ldt_lim) : CMP_W'(gdt_lim);
  assign tbl_base  = ti ? ldt_base : gdt_base;

  assign is_null    = (idx == '0) && !ti;
  assign over_limit = last_byte > lim_ext;
  assign desc_addr  = tbl_base + ADDR_W'(off);
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_ldr_pkg::*;
(
  input  logic [DESC_W-1:0] raw,
  output seg_cache_t        ent,
  output logic              present
);
  logic unused_rsvd;
  assign unused_rsvd = raw[53];

  always_comb begin
    ent          = '0;
    ent.limit    = {raw[51:48], raw[15:0]};
    ent.base     = {raw[63:56], raw[39:16]};
    ent.typ      = raw[43:40];
    ent.s        = raw[44];
    ent.dpl      = raw[46:45];
    ent.avl      = raw[52];
    ent.db       = raw[54];
    ent.gran     = raw[55];
    ent.unusable = 1'b0;
  end

  assign present = raw[47];
endmodule

// File: rtl/seg_cache_file.sv
module seg_cache_file
  import seg_ldr_pkg::*;
#(
  parameter int NSEG = 6,
  localparam int SEGW = $clog2(NSEG)
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SEGW-1:0] wr_idx,
  input  seg_cache_t      wr_data,
  input  logic [SEGW-1:0] rd_idx,
  output seg_cache_t      rd_data,
  input  logic            acc_req,
  input  logic [SEGW-1:0] acc_idx,
  output logic            acc_trap
);
  seg_cache_t ent [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent[g] <= CACHE_RST;
      end else if (wr_en && (int'(wr_idx) == g)) begin
        ent[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= CACHE_RST;
      acc_trap <= 1'b0;
    end else begin
      rd_data  <= (int'(rd_idx) < NSEG) ? ent[rd_idx] : CACHE_RST;
      acc_trap <= acc_req && (int'(acc_idx) < NSEG) && ent[acc_idx].unusable;
    end
  end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
  import seg_ldr_pkg::*;
#(
  parameter int NSEG      = 6,
  parameter int CODE_SEG  = 1,
  parameter int STACK_SEG = 2,
  parameter int ADDR_W    = 32,
  parameter int TLIM_W    = 16,
  localparam int SEGW     = $clog2(NSEG)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_tbl,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [TLIM_W-1:0] cfg_lim,
  input  logic              ld_req,
  input  logic [SEGW-1:0]   ld_seg,
  input  logic [15:0]       ld_sel,
  output logic              ld_busy,
  output logic              ld_done,
  output logic              ld_fault,
  output logic [1:0]        ld_cause,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [63:0]       mem_rdata,
  input  logic [SEGW-1:0]   rd_seg,
  output logic [15:0]       rd_sel,
  output logic [31:0]       rd_base,
  output logic [19:0]       rd_limit,
  output logic [3:0]        rd_type,
  output logic              rd_s,
  output logic [1:0]        rd_dpl,
  output logic              rd_avl,
  output logic              rd_db,
  output logic              rd_gran,
  output logic              rd_null,
  input  logic              acc_req,
  input  logic [SEGW-1:0]   acc_seg,
  output logic              acc_trap
);
  ldr_state_e        st;
  logic [SEGW-1:0]   seg_q;
  logic [15:0]       sel_q;
  logic [ADDR_W-1:0] gdt_base, ldt_base;
  logic [TLIM_W-1:0] gdt_lim, ldt_lim;

  logic              is_null, over_limit, present, cs_ss;
  logic [ADDR_W-1:0] desc_addr;
  seg_cache_t        desc_ent, wr_data, rd_ent;
  logic              wr_en;

  seg_sel_decode #(.ADDR_W(ADDR_W), .TLIM_W(TLIM_W)) i_dec (
    .sel_hi    (sel_q[15:2]),
    .gdt_base  (gdt_base),
    .gdt_lim   (gdt_lim),
    .ldt_base  (ldt_base),
    .ldt_lim   (ldt_lim),
    .is_null   (is_null),
    .over_limit(over_limit),
    .desc_addr (desc_addr)
  );

  seg_desc_unpack i_unp (
    .raw    (mem_rdata),
    .ent    (desc_ent),
    .present(present)
  );

  assign cs_ss = (int'(seg_q) == CODE_SEG) || (int'(seg_q) == STACK_SEG);

  // Cache write: a null data-segment load in CHECK, or a present descriptor in WAIT.
  assign wr_en = ((st == ST_CHECK) && is_null && !cs_ss) ||
                 ((st == ST_WAIT) && mem_valid && present);

  always_comb begin
    if (st == ST_CHECK) begin
      wr_data     = CACHE_RST;
      wr_data.sel = sel_q;
    end else begin
      wr_data          = desc_ent;
      wr_data.sel      = sel_q;
      wr_data.unusable = 1'b0;
    end
  end

  seg_cache_file #(.NSEG(NSEG)) i_cache (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (seg_q),
    .wr_data (wr_data),
    .rd_idx  (rd_seg),
    .rd_data (rd_ent),
    .acc_req (acc_req),
    .acc_idx (acc_seg),
    .acc_trap(acc_trap)
  );

  assign rd_sel   = rd_ent.sel;
  assign rd_base  = rd_ent.base;
  assign rd_limit = rd_ent.limit;
  assign rd_type  = rd_ent.typ;
  assign rd_s     = rd_ent.s;
  assign rd_dpl   = rd_ent.dpl;
  assign rd_avl   = rd_ent.avl;
  assign rd_db    = rd_ent.db;
  assign rd_gran  = rd_ent.gran;
  assign rd_null  = rd_ent.unusable;

  // Table base/limit registers
  always_ff @(posedge clk) begin
    if (rst) begin
      gdt_base <= '0;
      gdt_lim  <= '0;
      ldt_base <= '0;
      ldt_lim  <= '0;
    end else if (cfg_we) begin
      if (cfg_tbl) begin
        ldt_base <= cfg_base;
        ldt_lim  <= cfg_lim;
      end else begin
        gdt_base <= cfg_base;
        gdt_lim  <= cfg_lim;
      end
    end
  end

  // Load controller
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      seg_q    <= '0;
      sel_q    <= '0;
      ld_busy  <= 1'b0;
      ld_done  <= 1'b0;
      ld_fault <= 1'b0;
      ld_cause <= CAUSE_NONE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else begin
      ld_done  <= 1'b0;
      ld_fault <= 1'b0;
      ld_cause <= CAUSE_NONE;
      unique case (st)
        ST_IDLE: begin
          if (ld_req) begin
            seg_q   <= ld_seg;
            sel_q   <= ld_sel;
            ld_busy <= 1'b1;
            st      <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (is_null) begin
            ld_busy <= 1'b0;
            st      <= ST_IDLE;
            if (cs_ss) begin
              ld_fault <= 1'b1;
              ld_cause <= CAUSE_NULL_CS_SS;
            end else begin
              ld_done <= 1'b1;
            end
          end else if (over_limit) begin
            ld_busy  <= 1'b0;
            ld_fault <= 1'b1;
            ld_cause <= CAUSE_OVER_LIMIT;
            st       <= ST_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= desc_addr;
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_valid) begin
            mem_req <= 1'b0;
            ld_busy <= 1'b0;
            st      <= ST_IDLE;
            if (present) begin
              ld_done <= 1'b1;
            end else begin
              ld_fault <= 1'b1;
              ld_cause <= CAUSE_NOT_PRESENT;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seg_ldr_chk.sv
module seg_ldr_chk #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rst,
  input logic              ld_busy,
  input logic              ld_done,
  input logic              ld_fault,
  input logic [1:0]        ld_cause,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic              acc_req,
  input logic              acc_trap
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R1

  AST_LIMIT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (ld_fault && ld_cause == 2'd3) |-> $past(!mem_req)); // R2

  AST_TRAP_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    acc_trap |-> $past(acc_req)); // R4

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ld_done && ld_fault)); // R8

  AST_DONE_NO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ld_done |-> (ld_cause == 2'd0)); // R8

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ld_fault |-> (ld_cause != 2'd0)); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ld_done |=> !ld_done); // R8

  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ld_busy); // R9

  AST_OUTCOME_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ld_done || ld_fault) |-> !ld_busy); // R9
endmodule

bind seg_desc_loader seg_ldr_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .ld_busy  (ld_busy),
  .ld_done  (ld_done),
  .ld_fault (ld_fault),
  .ld_cause (ld_cause),
  .mem_req  (mem_req),
  .mem_addr (mem_addr),
  .mem_valid(mem_valid),
  .acc_req  (acc_req),
  .acc_trap (acc_trap)
);

// File: tb/test_seg_desc_loader.sv
`timescale 1ns/1ps
module test_seg_desc_loader;
  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] base;
    logic [19:0] limit;
    logic [3:0]  typ;
    logic        s;
    logic [1:0]  dpl;
    logic        avl;
    logic        db;
    logic        gran;
    logic        unus;
  } mseg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_tbl = 0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_lim = '0;
  logic ld_req = 0;
  logic [2:0] ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic ld_busy, ld_done, ld_fault;
  logic [1:0] ld_cause;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_valid = 0;
  logic [63:0] mem_rdata = '0;
  logic [2:0] rd_seg = '0;
  logic [15:0] rd_sel;
  logic [31:0] rd_base;
  logic [19:0] rd_limit;
  logic [3:0] rd_type;
  logic rd_s, rd_avl, rd_db, rd_gran, rd_null;
  logic [1:0] rd_dpl;
  logic acc_req = 0;
  logic [2:0] acc_seg = '0;
  logic acc_trap;

  always #2.5 clk = ~clk;

  seg_desc_loader i_seg_desc_loader (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_base(cfg_base), .cfg_lim(cfg_lim),
    .ld_req(ld_req), .ld_seg(ld_seg), .ld_sel(ld_sel),
    .ld_busy(ld_busy), .ld_done(ld_done), .ld_fault(ld_fault), .ld_cause(ld_cause),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .rd_seg(rd_seg), .rd_sel(rd_sel), .rd_base(rd_base), .rd_limit(rd_limit),
    .rd_type(rd_type), .rd_s(rd_s), .rd_dpl(rd_dpl), .rd_avl(rd_avl), .rd_db(rd_db),
    .rd_gran(rd_gran), .rd_null(rd_null),
    .acc_req(acc_req), .acc_seg(acc_seg), .acc_trap(acc_trap)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit force_np = 0;
  logic [31:0] gbase = '0, lbase = '0;
  int glim = 0, llim = 0;
  mseg_t model [6];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] desc_at(input logic [31:0] a);
    logic [63:0] d;
    d = {a ^ 32'hA5C3_1E7F, (a * 32'h0019_660D) + 32'h3C6E_F35F};
    d[47] = !force_np;
    return d;
  endfunction

  function automatic mseg_t unpack_exp(input logic [63:0] d, input logic [15:0] sel);
    mseg_t m;
    m.sel = sel;
    m.base = {d[63:56], d[39:16]};
    m.limit = {d[51:48], d[15:0]};
    m.typ = d[43:40];
    m.s = d[44];
    m.dpl = d[46:45];
    m.avl = d[52];
    m.db = d[54];
    m.gran = d[55];
    m.unus = 1'b0;
    return m;
  endfunction

  // Memory model: answers a held request after 1 to 4 cycles
  bit pend = 0;
  int cnt = 0;
  logic [31:0] paddr;
  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid = 1'b0;
    end else if (pend) begin
      if (cnt == 0) begin
        mem_valid = 1'b1;
        mem_rdata = desc_at(paddr);
        pend = 0;
      end else cnt--;
    end else if (mem_req && !rst) begin
      pend = 1;
      paddr = mem_addr;
      cnt = $urandom_range(0, 3);
    end
  end

  task automatic cfg(input bit tbl, input logic [31:0] b, input int lim);
    @(negedge clk);
    cfg_we = 1; cfg_tbl = tbl; cfg_base = b; cfg_lim = 16'(lim);
    @(negedge clk);
    cfg_we = 0;
    if (tbl) begin lbase = b; llim = lim; end
    else begin gbase = b; glim = lim; end
  endtask

  task automatic get_seg(input int seg, output mseg_t m, output logic trap);
    @(negedge clk);
    rd_seg = 3'(seg); acc_seg = 3'(seg); acc_req = 1;
    @(negedge clk);
    acc_req = 0;
    m = '{sel: rd_sel, base: rd_base, limit: rd_limit, typ: rd_type, s: rd_s,
          dpl: rd_dpl, avl: rd_avl, db: rd_db, gran: rd_gran, unus: rd_null};
    trap = acc_trap;
  endtask

  task automatic check_seg(input int seg, input string tag);
    mseg_t m;
    logic trap;
    get_seg(seg, m, trap);
    chk(m == model[seg], tag, 128'(m), 128'(model[seg]));
    chk(trap == model[seg].unus, tag, 128'(trap), 128'(model[seg].unus));
  endtask

  task automatic do_load(input int seg, input logic [15:0] sel, input bit extra, input string tag);
    int idx, last, lim, ecause, cyc;
    bit ti, nul, emem, got_mem, got_done, got_fault, seen;
    logic [31:0] eaddr, gaddr;
    logic [63:0] d;
    logic [1:0] gcause;
    idx = int'(sel[15:3]); ti = sel[2];
    nul = (idx == 0) && !ti;
    emem = 0; eaddr = '0; ecause = 0;
    if (nul) begin
      ecause = (seg == 1 || seg == 2) ? 1 : 0;
      if (ecause == 0) model[seg] = '{sel: sel, unus: 1'b1, default: '0};
    end else begin
      last = idx * 8 + 7;
      lim = ti ? llim : glim;
      if (last > lim) ecause = 3;
      else begin
        emem = 1;
        eaddr = (ti ? lbase : gbase) + 32'(idx * 8);
        d = desc_at(eaddr);
        ecause = d[47] ? 0 : 2;
        if (ecause == 0) model[seg] = unpack_exp(d, sel);
      end
    end
    @(negedge clk);
    ld_req = 1; ld_seg = 3'(seg); ld_sel = sel;
    @(negedge clk);
    ld_req = 0;
    got_mem = 0; got_done = 0; got_fault = 0; gaddr = '0; gcause = '0;
    cyc = 0;
    while (!(ld_done || ld_fault) && cyc < 50) begin
      chk(ld_busy == 1'b1, "R9 busy during load", 128'(ld_busy), 128'(1));
      if (mem_req && !got_mem) begin got_mem = 1; gaddr = mem_addr; end
      if (extra && cyc == 0) begin
        ld_req = 1; ld_seg = 3'(seg ^ 1); ld_sel = 16'h0000;
      end else ld_req = 0;
      @(negedge clk);
      cyc++;
    end
    ld_req = 0;
    got_done = ld_done; got_fault = ld_fault; gcause = ld_cause;
    chk(got_done || got_fault, {tag, " outcome seen"}, 128'(cyc), 128'(0));
    chk(got_done == (ecause == 0) && got_fault == (ecause != 0), {tag, " R8 outcome kind"},
        128'({got_done, got_fault}), 128'({ecause == 0, ecause != 0}));
    chk(gcause == 2'(ecause), {tag, " cause"}, 128'(gcause), 128'(ecause));
    chk(ld_busy == 1'b0, "R9 busy low at outcome", 128'(ld_busy), 128'(0));
    chk(got_mem == emem, {tag, " read issued"}, 128'(got_mem), 128'(emem));
    if (emem) chk(gaddr == eaddr, {tag, " R1 address"}, 128'(gaddr), 128'(eaddr));
    seen = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (ld_done || ld_fault || ld_busy) seen = 1;
    end
    chk(!seen, "R9 R8 no second outcome", 128'(seen), 128'(0));
    check_seg(seg, {tag, " R6 R7 cache readback"});
  endtask

  initial begin
    #500000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) model[i] = '{unus: 1'b1, default: '0};
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk({ld_busy, ld_done, ld_fault, mem_req} == 4'b0, "R10 idle after reset",
        128'({ld_busy, ld_done, ld_fault, mem_req}), 128'(0));
    for (int s = 0; s < 6; s++) check_seg(s, "R10 reset entry");

    // R11 table setup
    cfg(0, 32'h1000_0000, 16'h00FF);
    cfg(1, 32'h2000_0100, 16'h07FF);

    do_load(3, {13'd5, 1'b0, 2'd1}, 0, "R1 global load");
    do_load(1, {13'd7, 1'b1, 2'd0}, 0, "R1 local load");
    do_load(4, {13'd0, 1'b1, 2'd3}, 0, "R1 local index zero");
    // R3 null into code and stack
    do_load(1, 16'h0000, 0, "R3 null code");
    do_load(2, 16'h0001, 0, "R3 null stack");
    // R4 null into data register that held a valid load
    do_load(3, 16'h0002, 0, "R4 null data");
    // R7 reload clears null marker
    do_load(3, {13'd9, 1'b0, 2'd2}, 0, "R7 reload");
    // R2 boundaries
    do_load(0, {13'd31, 1'b0, 2'd0}, 0, "R2 last slot fits");
    do_load(0, {13'd32, 1'b0, 2'd0}, 0, "R2 one past limit");
    do_load(5, {13'd256, 1'b1, 2'd0}, 0, "R2 local past limit");
    do_load(5, {13'd255, 1'b1, 2'd0}, 0, "R2 local last slot");
    // R5 present clear leaves entry unchanged
    force_np = 1;
    do_load(4, {13'd3, 1'b0, 2'd0}, 0, "R5 not present");
    force_np = 0;
    // R9 request while busy is ignored
    do_load(3, {13'd3, 1'b1, 2'd1}, 1, "R9 busy ignore");
    // R11 rewrite global table
    cfg(0, 32'h0040_0000, 16'h01FF);
    do_load(2, {13'd60, 1'b0, 2'd0}, 0, "R11 new global base");
    do_load(2, {13'd64, 1'b0, 2'd0}, 0, "R11 new global limit");

    for (int n = 0; n < 60; n++) begin
      int seg, r;
      logic [15:0] sel;
      string tag;
      seg = $urandom_range(0, 5);
      r = $urandom_range(0, 7);
      force_np = ($urandom_range(0, 7) == 0);
      if (r == 0) sel = {13'd0, 1'b0, 2'($urandom_range(0, 3))};
      else if (r < 4) sel = {13'($urandom_range(0, 70)), 1'b0, 2'($urandom_range(0, 3))};
      else sel = {13'($urandom_range(0, 260)), 1'b1, 2'($urandom_range(0, 3))};
      tag = "R7 R2 R3 R4 R5 random load";
      do_load(seg, sel, (n % 5) == 0, tag);
    end
    force_np = 0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule